// File: doc/BRIEF.md
# Path Trace Message Monitor

This block watches the path trace byte that arrives once per frame on a single path. It checks the byte sequence against an expected message that the host has loaded into a small table. Two message layouts are supported, and a mode input selects between them. The long layout is a fixed-length message. Its alignment comes from the line-feed character (0x0A): the byte that follows a line feed is message position 0. The short layout is a shorter message whose first byte is marked by bit 7 being set.

Any received byte that differs from the expected byte at its position raises a mismatch state. That state drops only after a full message length of consecutive matching bytes. Every change of the mismatch state sets a sticky change flag. The host clears the flag by writing 1 to it. An interrupt output follows the flag unless a mask input blocks it.

Top module: `ptrace_mon`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `mismatch`, `delta` and `irq` are 0, and the message position is 0.
- R2: With `mode` = 2'b01 (long layout), each valid byte is compared with table entry `pos`. The next byte goes to entry 0 if the current byte is 0x0A, or if `pos` was LONG_LEN-1. Otherwise the position advances by one.
- R3: With `mode` = 2'b10 (short layout), a valid byte with bit 7 = 1 is compared with entry 0, and the following bytes are compared with entries 1, 2 and onward. The position wraps from SHORT_LEN-1 to 0.
- R4: A valid byte that differs from its expected entry sets `mismatch` at the clock edge that samples it.
- R5: `mismatch` returns to 0 only at the edge that samples the n-th consecutive matching valid byte, where n is the message length of the active layout. Any differing byte restarts the count.
- R6: With `mode` = 2'b00 or 2'b11, no comparison takes place, and `mismatch` and `delta` keep their values whatever bytes arrive.
- R7: Every edge at which `mismatch` changes value also sets `delta`, and `delta` then stays at 1.
- R8: A `delta_clr` pulse clears `delta` at the next edge. If `mismatch` changes at that same edge, `delta` stays 1.
- R9: `irq` is 1 exactly when `delta` is 1 and `irq_mask` is 0.
- R10: A host write (`exp_wr` = 1) stores `exp_data` at entry `exp_addr`. Bytes presented with `trace_vld` = 0 are not compared and do not move the position.
- R11: On the first cycle after any change of `mode`, no comparison takes place and the position and match count return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_byte | input | 8 | Received path trace byte |
| trace_vld | input | 1 | One-cycle strobe, once per frame, qualifying `trace_byte` |
| mode | input | 2 | 01 long layout, 10 short layout, 00/11 no monitoring |
| exp_wr | input | 1 | Host write enable for the expected-message table |
| exp_addr | input | $clog2(LONG_LEN) | Table entry to write |
| exp_data | input | 8 | Expected byte to store |
| delta_clr | input | 1 | Host write-1-to-clear for `delta` |
| irq_mask | input | 1 | 1 blocks `delta` from reaching `irq` |
| mismatch | output | 1 | Trace mismatch state |
| delta | output | 1 | Sticky flag: mismatch state changed |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with LONG_LEN = 12 and SHORT_LEN = 4. A length that is not a power of two means the long-layout wrap has to come from the length compare and cannot happen by counter overflow. Both lengths are short enough that a full clear window, a realignment on a start marker and a wrap with no marker present can each be exercised in a few dozen frames. The same settings also cover the set-over-clear collision on the change flag and the position reset on a mode change.

// File: rtl/ptrace_mon.sv
module ptrace_mon #(
  parameter int LONG_LEN  = 64,
  parameter int SHORT_LEN = 16,
  parameter logic [7:0] MARK = 8'h0A,
  localparam int AW = $clog2(LONG_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    trace_byte,
  input  logic          trace_vld,
  input  logic [1:0]    mode,
  input  logic          exp_wr,
  input  logic [AW-1:0] exp_addr,
  input  logic [7:0]    exp_data,
  input  logic          delta_clr,
  input  logic          irq_mask,
  output logic          mismatch,
  output logic          delta,
  output logic          irq
);
  localparam logic [1:0] MODE_LONG  = 2'b01;
  localparam logic [1:0] MODE_SHORT = 2'b10;
  localparam logic [AW:0] LLEN = (AW+1)'(LONG_LEN);
  localparam logic [AW:0] SLEN = (AW+1)'(SHORT_LEN);

  logic [7:0]    tbl [LONG_LEN];
  logic [AW-1:0] pos;
  logic [AW:0]   good;
  logic [1:0]    mode_q;
  logic          mis_nxt;

  always_ff @(posedge clk)
    if (exp_wr) tbl[exp_addr] <= exp_data;

  wire          long_m  = (mode == MODE_LONG);
  wire          short_m = (mode == MODE_SHORT);
  wire          restart = (mode != mode_q);
  wire          check   = trace_vld & (long_m | short_m) & ~restart;
  wire [AW:0]   len     = long_m ? LLEN : SLEN;
  wire [AW-1:0] idx     = (short_m & trace_byte[7]) ? '0 : pos;
  wire          hit     = (trace_byte == tbl[idx]);
  wire          wrap    = ({1'b0, idx} == len - 1'b1);
  wire          full    = (good == len - 1'b1);
  wire [AW-1:0] pos_nxt = ((long_m && trace_byte == MARK) || wrap) ? '0 : idx + 1'b1;

  always_comb begin
    mis_nxt = mismatch;
    if (check) begin
      if (!hit)      mis_nxt = 1'b1;
      else if (full) mis_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      good     <= '0;
      mode_q   <= '0;
      mismatch <= 1'b0;
      delta    <= 1'b0;
    end else begin
      mode_q   <= mode;
      mismatch <= mis_nxt;
      if (restart) begin
        pos  <= '0;
        good <= '0;
      end else if (check) begin
        pos  <= pos_nxt;
        good <= (!hit || full) ? '0 : good + 1'b1;
      end
      if (mis_nxt != mismatch) delta <= 1'b1;
      else if (delta_clr)      delta <= 1'b0;
    end
  end

  assign irq = delta & ~irq_mask;
endmodule

// File: rtl/ptrace_mon_chk.sv
module ptrace_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trace_vld,
  input logic [1:0] mode,
  input logic       delta_clr,
  input logic       irq_mask,
  input logic       mismatch,
  input logic       delta,
  input logic       irq
);
  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!mismatch && !delta));

  // R5: the state can only drop on a valid byte
  a_r5_clear_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mismatch) |-> $past(trace_vld));

  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |=> $stable(mismatch));

  a_r7_delta_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mismatch) |-> delta);

  a_r8_delta_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (delta && !delta_clr) |=> delta);

  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);
endmodule

bind ptrace_mon ptrace_mon_chk u_chk (.*);

// File: tb/ptrace_mon_test.sv
module ptrace_mon_test;
  localparam int LL = 12;
  localparam int SL = 4;
  localparam int AW = $clog2(LL);

  logic clk = 0, rst_n = 0;
  logic [7:0] trace_byte = 0;
  logic trace_vld = 0, exp_wr = 0, delta_clr = 0, irq_mask = 0;
  logic [1:0] mode = 0;
  logic [AW-1:0] exp_addr = 0;
  logic [7:0] exp_data = 0;
  logic mismatch, delta, irq;

  ptrace_mon #(.LONG_LEN(LL), .SHORT_LEN(SL)) uut (.*);

  always #4 clk = ~clk;

  typedef struct { logic m; logic d; logic i; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [7:0] lmsg(int i);
    return (i == LL-1) ? 8'h0A : 8'h41 + 8'(i);
  endfunction

  task automatic wr(int a, logic [7:0] d);
    exp_wr = 1; exp_addr = AW'(a); exp_data = d;
    @(posedge clk); @(negedge clk);
    exp_wr = 0;
  endtask

  task automatic cyc(logic v, logic [7:0] b, logic c, logic em, logic ed, string tag);
    item_t it;
    trace_vld = v; trace_byte = b; delta_clr = c;
    it.m = em; it.d = ed; it.i = ed & ~irq_mask; it.tag = tag;
    q.push_back(it);
    @(posedge clk); @(negedge clk);
    trace_vld = 0; delta_clr = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (mismatch !== it.m || delta !== it.d || irq !== it.i) begin
          errors++;
          $display("FAIL %s: mismatch/delta/irq=%b%b%b expected %b%b%b",
                   it.tag, mismatch, delta, irq, it.m, it.d, it.i);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    checks++;
    if (mismatch !== 0 || delta !== 0 || irq !== 0) begin
      errors++;
      $display("FAIL R1: mismatch/delta/irq=%b%b%b expected 000", mismatch, delta, irq);
    end
    for (int i = 0; i < LL; i++) wr(i, lmsg(i));
    // idle mode ignores bytes
    for (int i = 0; i < 3; i++) cyc(1, 8'h77, 0, 0, 0, "R6");
    mode = 2'b01;
    cyc(0, 8'hFF, 0, 0, 0, "R11");
    cyc(1, 8'h0A, 0, 1, 1, "R7");
    for (int i = 0; i < LL; i++) cyc(1, lmsg(i), 0, (i < LL-1), 1, "R5");
    cyc(0, 8'h00, 1, 0, 0, "R8");
    for (int i = 0; i < LL; i++) cyc(1, lmsg(i), 0, 0, 0, "R2");
    cyc(1, lmsg(0), 0, 0, 0, "R2");
    cyc(1, 8'h99, 1, 1, 1, "R8");
    for (int i = 2; i < LL; i++) cyc(1, lmsg(i), 0, 1, 1, "R5");
    cyc(1, lmsg(0), 0, 1, 1, "R5");
    cyc(1, lmsg(1), 0, 0, 1, "R5");
    for (int i = 2; i < LL; i++) cyc(1, lmsg(i), 0, 0, 1, "R2");
    irq_mask = 1;
    cyc(0, 8'h55, 0, 0, 1, "R9");
    cyc(0, 8'h00, 1, 0, 0, "R8");
    irq_mask = 0;
    cyc(0, 8'h13, 0, 0, 0, "R10");
    cyc(0, 8'h14, 0, 0, 0, "R10");
    // wrap by length with no line feed present
    wr(LL-1, 8'h5A);
    for (int i = 0; i < LL-1; i++) cyc(1, lmsg(i), 0, 0, 0, "R2");
    cyc(1, 8'h5A, 0, 0, 0, "R2");
    cyc(1, lmsg(0), 0, 0, 0, "R2");
    cyc(1, lmsg(1), 0, 0, 0, "R2");
    // short layout
    wr(0, 8'hD0); wr(1, 8'h51); wr(2, 8'h52); wr(3, 8'h53);
    mode = 2'b10;
    cyc(0, 8'h00, 0, 0, 0, "R11");
    cyc(1, 8'h51, 0, 1, 1, "R4");
    cyc(1, 8'hD0, 0, 1, 1, "R3");
    cyc(1, 8'h51, 0, 1, 1, "R3");
    cyc(1, 8'h52, 0, 1, 1, "R3");
    cyc(1, 8'h53, 0, 0, 1, "R5");
    cyc(0, 8'h00, 1, 0, 0, "R8");
    cyc(1, 8'hD0, 0, 0, 0, "R3");
    cyc(1, 8'h51, 0, 0, 0, "R3");
    cyc(1, 8'hD0, 0, 0, 0, "R3");
    cyc(1, 8'h51, 0, 0, 0, "R3");
    cyc(1, 8'h52, 0, 0, 0, "R3");
    cyc(1, 8'h53, 0, 0, 0, "R3");
    cyc(1, 8'h51, 0, 1, 1, "R3");
    cyc(1, 8'hD0, 0, 1, 1, "R3");
    cyc(1, 8'h51, 0, 1, 1, "R3");
    cyc(1, 8'h52, 0, 1, 1, "R3");
    cyc(1, 8'h53, 0, 0, 1, "R5");
    cyc(0, 8'h00, 1, 0, 0, "R8");
    cyc(1, 8'hD0, 0, 0, 0, "R3");
    cyc(1, 8'h51, 0, 0, 0, "R3");
    mode = 2'b00;
    cyc(0, 8'h00, 0, 0, 0, "R11");
    cyc(1, 8'h00, 0, 0, 0, "R6");
    mode = 2'b10;
    cyc(0, 8'h00, 0, 0, 0, "R11");
    cyc(1, 8'h52, 0, 1, 1, "R11");
    mode = 2'b11;
    cyc(0, 8'h00, 0, 1, 1, "R11");
    cyc(1, 8'hD0, 0, 1, 1, "R6");
    cyc(1, 8'h51, 0, 1, 1, "R6");
    cyc(1, 8'h52, 0, 1, 1, "R6");
    cyc(1, 8'h53, 0, 1, 1, "R6");
    cyc(1, 8'h53, 0, 1, 1, "R6");
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule